// File: doc/BRIEF.md
# Transmit Frame Builder for 36-bit Host Words

The block gathers payload bytes from 36-bit host data words into a byte buffer of up to 514 bytes. Each word carries up to four bytes, taken from the odd bit fields that sit above the four low pad bits. A swap mode reverses the byte order within each 16-bit half. A half-word mode takes only the upper half of each word.

When the host issues go, the block checks the length and copies payload bytes 8 and 9 to the end of the payload as a trailer. It then passes the payload and trailer, as big-endian 16-bit words, to an external checksum unit, appends the returned checksum high byte first, and streams the whole frame out on a byte interface with valid, ready and last. The block keeps two status bits, transmit-done and length-error. While a frame is being built or sent, busy_o is high and the host must hold off.

Top module: `tfb_frame_builder`

## Requirements
- R1: With swap and half-word off, a taken write stores word bits 35:28, 27:20, 19:12 and 11:4 as the next four payload bytes, in that order, and the count advances by 4.
- R2: With swap on, a taken write stores bits 27:20, 35:28, 11:4, 19:12, in that order.
- R3: With half-word on, a taken write stores only the first two bytes of the R1/R2 order, and the count advances by 2.
- R4: A write taken while the count is at or above 514 stores nothing and sets len_err_o.
- R5: After reset, tx_done_o=1, len_err_o=0, busy_o=0 and out_valid_o=0. Any taken write clears tx_done_o.
- R6: A go with a count above 510 sends nothing, leaves busy_o low, sets len_err_o and keeps the count. A go with exactly 510 bytes sends a 514-byte frame.
- R7: A frame is the payload, then copies of payload bytes 8 and 9, then checksum bits 15:8 and 7:0. out_last_o is high on the final checksum byte only.
- R8: After a one-cycle ck_init_o pulse, the block presents the payload plus trailer on ck_word_o as 16-bit words, with the even byte in bits 15:8, one word per ck_valid_o cycle. It takes ck_sum_i in the cycle after the last word.
- R9: When the last byte is accepted, the count returns to 0, tx_done_o is set and busy_o falls.
- R10: While busy_o is high, writes and go are not taken. A byte that is offered and not accepted holds its data and last.
- R11: clr_tx_i zeroes the count, sets tx_done_o and clears len_err_o. In the same cycle, clear wins over go and go wins over write, and the losing request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host data write request |
| wr_data_i | input | 36 | Host data word |
| swap_i | input | 1 | Swap bytes within each 16-bit half |
| half_i | input | 1 | Store only the upper half of each word |
| clr_tx_i | input | 1 | Clear the transmitter |
| go_i | input | 1 | Build and send the frame |
| busy_o | output | 1 | Frame in progress; requests not taken |
| tx_done_o | output | 1 | Transmit-done status |
| len_err_o | output | 1 | Length-error status |
| ck_init_o | output | 1 | Restart the external checksum |
| ck_valid_o | output | 1 | ck_word_o carries a word to sum |
| ck_word_o | output | 16 | Word to sum, even byte high |
| ck_sum_i | input | 16 | Final checksum from the external unit |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the frame |

## Verification
Two pairs of host requests can arrive in the same cycle: a data write together with go, and go together with clear. The bench raises both signals of each pair on the same edge. It judges the outcome from the next frame: a write that lost to go must not appear in the frame just sent, and after a clear that beat go, the following frame must hold only the data written afterwards. Requests raised while busy, and stalls on out_ready_i, are judged the same way, by comparing the emitted frames byte for byte against a reference model.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
  localparam int unsigned WORD_W = 36;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPEND,
    ST_SUM,
    ST_CKWAIT,
    ST_SEND
  } tfb_state_e;
endpackage

// File: rtl/tfb_pack.sv
module tfb_pack
  import tfb_pkg::*;
(
  input  logic [WORD_W-1:0]             word_i,
  input  logic                          swap_i,
  input  logic                          half_i,
  output logic [LANES-1:0][BYTE_W-1:0]  lane_o,
  output logic [LANES-1:0]              mask_o,
  output logic [2:0]                    step_o
);
  localparam int unsigned HALF_LANES = LANES / 2;

  // low pad bits carry no payload
  logic unused_pad;
  assign unused_pad = ^word_i[WORD_W-LANES*BYTE_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned SRC = l;
    localparam int unsigned ALT = l ^ 1;
    assign lane_o[l] = swap_i ? word_i[WORD_W-1-BYTE_W*ALT -: BYTE_W]
                              : word_i[WORD_W-1-BYTE_W*SRC -: BYTE_W];
  end

  assign mask_o = half_i ? LANES'((1 << HALF_LANES) - 1) : {LANES{1'b1}};
  assign step_o = half_i ? 3'(HALF_LANES) : 3'(LANES);
endmodule

// File: rtl/tfb_buf.sv
module tfb_buf
  import tfb_pkg::*;
#(
  parameter int unsigned DEPTH = 514,
  parameter int unsigned IDX_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0]              we_i,
  input  logic [IDX_W-1:0]              wbase_i,
  input  logic [LANES-1:0][BYTE_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0]              ra_i,
  output logic [BYTE_W-1:0]             rd0_o,
  output logic [BYTE_W-1:0]             rd1_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  lane_idx [LANES];
  logic [LANES-1:0]  lane_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_widx
    assign lane_idx[l] = wbase_i + IDX_W'(l);
    assign lane_ok[l]  = we_i[l] && (lane_idx[l] < IDX_W'(DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_ok[l]) mem_q[lane_idx[l]] <= wdata_i[l];
    end
  end

  logic [IDX_W-1:0] ra1;
  assign ra1   = ra_i + IDX_W'(1);
  assign rd0_o = (ra_i < IDX_W'(DEPTH)) ? mem_q[ra_i] : '0;
  assign rd1_o = (ra1  < IDX_W'(DEPTH)) ? mem_q[ra1]  : '0;
endmodule

// File: rtl/tfb_frame_builder.sv
module tfb_frame_builder
  import tfb_pkg::*;
#(
  parameter int unsigned BUF_BYTES   = 514,
  parameter int unsigned MAX_PAYLOAD = 510,
  parameter int unsigned TRAIL_IDX   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              swap_i,
  input  logic              half_i,
  input  logic              clr_tx_i,
  input  logic              go_i,
  output logic              busy_o,
  output logic              tx_done_o,
  output logic              len_err_o,
  output logic              ck_init_o,
  output logic              ck_valid_o,
  output logic [15:0]       ck_word_o,
  input  logic [15:0]       ck_sum_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_last_o
);
  localparam int unsigned CNT_W = $clog2(BUF_BYTES + 5);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(BUF_BYTES);
  localparam logic [CNT_W-1:0] MAXP_C  = CNT_W'(MAX_PAYLOAD);
  localparam logic [CNT_W-1:0] TRAIL_C = CNT_W'(TRAIL_IDX);
  localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);

  tfb_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, len_q, ptr_q;
  logic             done_q, err_q;

  logic idle, take_clr, take_go, take_wr, go_ok, cnt_full;
  assign idle     = (state_q == ST_IDLE);
  assign take_clr = idle && clr_tx_i;
  assign take_go  = idle && go_i && !clr_tx_i;
  assign take_wr  = idle && wr_valid_i && !go_i && !clr_tx_i;
  assign go_ok    = (cnt_q <= MAXP_C);
  assign cnt_full = (cnt_q >= FULL_C);

  logic [LANES-1:0][BYTE_W-1:0] pk_lane;
  logic [LANES-1:0]             pk_mask;
  logic [2:0]                   pk_step;

  tfb_pack u_pack (
    .word_i (wr_data_i),
    .swap_i (swap_i),
    .half_i (half_i),
    .lane_o (pk_lane),
    .mask_o (pk_mask),
    .step_o (pk_step)
  );

  logic [LANES-1:0]             buf_we;
  logic [CNT_W-1:0]             buf_base, buf_ra;
  logic [LANES-1:0][BYTE_W-1:0] buf_wd;
  logic [BYTE_W-1:0]            rd0, rd1;

  always_comb begin
    buf_we   = '0;
    buf_base = cnt_q;
    buf_wd   = pk_lane;
    buf_ra   = ptr_q;
    unique case (state_q)
      ST_IDLE: if (take_wr && !cnt_full) buf_we = pk_mask;
      ST_APPEND: begin
        buf_ra    = TRAIL_C;
        buf_we    = LANES'(2'b11);
        buf_wd[0] = rd0;
        buf_wd[1] = rd1;
      end
      ST_CKWAIT: begin
        buf_base  = len_q;
        buf_we    = LANES'(2'b11);
        buf_wd[0] = ck_sum_i[15:8];
        buf_wd[1] = ck_sum_i[7:0];
      end
      default: ;
    endcase
  end

  tfb_buf #(
    .DEPTH (BUF_BYTES),
    .IDX_W (CNT_W)
  ) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .wbase_i (buf_base),
    .wdata_i (buf_wd),
    .ra_i    (buf_ra),
    .rd0_o   (rd0),
    .rd1_o   (rd1)
  );

  logic send_last, send_fire;
  assign send_last = (state_q == ST_SEND) && (ptr_q == len_q - CNT_W'(1));
  assign send_fire = (state_q == ST_SEND) && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_clr) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
            err_q  <= 1'b0;
          end else if (take_go) begin
            if (go_ok) state_q <= ST_APPEND;
            else       err_q   <= 1'b1;
          end else if (take_wr) begin
            done_q <= 1'b0;
            if (cnt_full) err_q <= 1'b1;
            else          cnt_q <= cnt_q + CNT_W'(pk_step);
          end
        end
        ST_APPEND: begin
          len_q   <= cnt_q + TWO_C;
          ptr_q   <= '0;
          state_q <= ST_SUM;
        end
        ST_SUM: begin
          if (ptr_q + TWO_C == len_q) begin
            ptr_q   <= '0;
            state_q <= ST_CKWAIT;
          end else begin
            ptr_q <= ptr_q + TWO_C;
          end
        end
        ST_CKWAIT: begin
          len_q   <= len_q + TWO_C;
          ptr_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (send_fire) begin
            if (send_last) begin
              cnt_q   <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              ptr_q <= ptr_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign tx_done_o   = done_q;
  assign len_err_o   = err_q;
  assign ck_init_o   = (state_q == ST_APPEND);
  assign ck_valid_o  = (state_q == ST_SUM);
  assign ck_word_o   = {rd0, rd1};
  assign out_valid_o = (state_q == ST_SEND);
  assign out_data_o  = rd0;
  assign out_last_o  = send_last;

  p_wr_clears_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_wr |=> !tx_done_o);
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_wr && cnt_full |=> len_err_o);
  p_long_go_refused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_go && !go_ok |=> !busy_o && len_err_o && !out_valid_o);
  p_init_then_sum_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_init_o |=> ck_valid_o && !ck_init_o);
  p_last_in_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  p_frame_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> tx_done_o && !busy_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_clr |=> tx_done_o && !len_err_o && !busy_o);
endmodule

// File: tb/tfb_frame_builder_tb.sv
`timescale 1ns/1ps
module tfb_frame_builder_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 1'b0;
  logic [35:0] wr_data_i = '0;
  logic swap_i = 1'b0, half_i = 1'b0, clr_tx_i = 1'b0, go_i = 1'b0;
  logic busy_o, tx_done_o, len_err_o, ck_init_o, ck_valid_o;
  logic [15:0] ck_word_o, ck_sum_i;
  logic out_valid_o, out_ready_i = 1'b0, out_last_o;
  logic [7:0] out_data_o;

  always #2.5 clk_i = ~clk_i;

  tfb_frame_builder u_dut (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .swap_i, .half_i, .clr_tx_i, .go_i,
    .busy_o, .tx_done_o, .len_err_o, .ck_init_o, .ck_valid_o, .ck_word_o, .ck_sum_i,
    .out_valid_o, .out_ready_i, .out_data_o, .out_last_o
  );

  // external checksum unit: end-around-carry accumulator
  logic [15:0] acc_q;
  logic [16:0] acc_sum;
  assign acc_sum  = {1'b0, acc_q} + {1'b0, ck_word_o};
  assign ck_sum_i = ~acc_q;
  always @(posedge clk_i) begin
    if (ck_init_o)       acc_q <= '0;
    else if (ck_valid_o) acc_q <= acc_sum[15:0] + {15'd0, acc_sum[16]};
  end

  int n_chk = 0, n_bad = 0;
  bit wd_hit = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [7:0] mb [516];
  int m_cnt = 0;
  bit m_done = 1, m_err = 0;
  logic [7:0] ef [516];
  int e_len = 0;
  logic [7:0] gf [600];
  logic       gl [600];
  int g_len = 0;

  function automatic logic [7:0] fld(input logic [35:0] d, input int k);
    return d[35-8*k -: 8];
  endfunction

  task automatic m_write(input logic [35:0] d);
    int ord [4];
    m_done = 0;
    if (m_cnt >= 514) begin m_err = 1; return; end
    ord = swap_i ? '{1, 0, 3, 2} : '{0, 1, 2, 3};
    for (int k = 0; k < (half_i ? 2 : 4); k++)
      if (m_cnt + k < 514) mb[m_cnt + k] = fld(d, ord[k]);
    m_cnt += half_i ? 2 : 4;
  endtask

  // returns 1 when a frame is expected
  function automatic bit m_go();
    int unsigned s;
    int l;
    logic [15:0] ck;
    if (m_cnt > 510) begin m_err = 1; return 0; end
    mb[m_cnt] = mb[8];
    mb[m_cnt + 1] = mb[9];
    l = m_cnt + 2;
    s = 0;
    for (int i = 0; i < l; i += 2) s += {16'd0, mb[i], mb[i+1]};
    while (s >> 16 != 0) s = (s & 32'hffff) + (s >> 16);
    ck = ~s[15:0];
    mb[l] = ck[15:8];
    mb[l+1] = ck[7:0];
    e_len = l + 2;
    for (int i = 0; i < e_len; i++) ef[i] = mb[i];
    m_cnt = 0;
    m_done = 1;
    return 1;
  endfunction

  task automatic do_wr(input logic [35:0] d);
    @(negedge clk_i);
    wr_valid_i = 1; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 0;
    m_write(d);
  endtask

  task automatic do_clr();
    @(negedge clk_i); clr_tx_i = 1;
    @(negedge clk_i); clr_tx_i = 0;
    m_cnt = 0; m_done = 1; m_err = 0;
  endtask

  // collect a frame; bp adds stalls, poke raises write/go while busy
  task automatic collect(input bit bp, input bit poke);
    int cyc = 0;
    bit fin = 0;
    g_len = 0;
    while (!fin && cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
      out_ready_i = bp ? ((cyc % 3) != 2) : 1'b1;
      if (poke) begin
        wr_valid_i = (cyc >= 2 && cyc <= 5);
        go_i       = (cyc >= 2 && cyc <= 5);
        wr_data_i  = 36'hbad_cafe_0;
      end
      if (out_valid_o && out_ready_i) begin
        gf[g_len] = out_data_o;
        gl[g_len] = out_last_o;
        g_len++;
        if (out_last_o) fin = 1;
      end
    end
    @(negedge clk_i);
    out_ready_i = 0; wr_valid_i = 0; go_i = 0;
  endtask

  task automatic cmp_frame(input string tag);
    int bad = -1;
    check(g_len == e_len, {tag, " R7 frame length"}, g_len, e_len);
    for (int i = 0; i < e_len && i < g_len; i++)
      if (bad < 0 && (gf[i] !== ef[i] || gl[i] !== (i == e_len - 1))) bad = i;
    if (bad >= 0)
      check(0, {tag, " R7 R8 byte/last at index ", $sformatf("%0d", bad)},
            {gl[bad], gf[bad]}, {(bad == e_len - 1), ef[bad]});
    else
      check(1, tag, 0, 0);
    check(tx_done_o === 1 && busy_o === 0, {tag, " R9 done/busy after frame"},
          {tx_done_o, busy_o}, 2'b10);
  endtask

  task automatic do_go(input string tag, input bit bp, input bit poke);
    bit exp_send;
    exp_send = m_go();
    @(negedge clk_i); go_i = 1;
    @(negedge clk_i); go_i = 0;
    if (exp_send) begin
      collect(bp, poke);
      cmp_frame(tag);
    end else begin
      repeat (3) @(negedge clk_i);
      check(busy_o === 0 && out_valid_o === 0, {tag, " R6 refused go stays idle"},
            {busy_o, out_valid_o}, 0);
      check(len_err_o === 1, {tag, " R6 len_err on long go"}, len_err_o, 1);
    end
  endtask

  task automatic t_reset();
    check(tx_done_o === 1, "R5 reset tx_done", tx_done_o, 1);
    check(len_err_o === 0, "R5 reset len_err", len_err_o, 0);
    check(busy_o === 0 && out_valid_o === 0, "R5 reset idle", {busy_o, out_valid_o}, 0);
  endtask

  task automatic t_normal();
    swap_i = 0; half_i = 0;
    do_wr(36'h123_4567_8);
    check(tx_done_o === 0, "R5 write clears tx_done", tx_done_o, 0);
    do_wr(36'h9ab_cdef_1);
    do_wr(36'h0f1_e2d3_c);
    do_wr(36'h5a6_9788_f);
    do_go("R1 plain words", 0, 0);
  endtask

  task automatic t_swap();
    swap_i = 1; half_i = 0;
    for (int i = 0; i < 5; i++) do_wr({8'(8'h11 * i + 1), 8'(8'h22 + i), 8'(8'h40 | i), 8'(8'hc0 - i), 4'h9});
    do_go("R2 swapped words", 0, 0);
    swap_i = 0;
  endtask

  task automatic t_half();
    half_i = 1;
    for (int i = 0; i < 7; i++) begin
      swap_i = i[0];
      do_wr({8'(8'h70 + i), 8'(8'h81 * i), 8'hee, 8'hdd, 4'h3});
    end
    do_go("R3 half words", 0, 0);
    half_i = 0; swap_i = 0;
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 4; i++) do_wr({4'(i), 32'h3c5a_96e1 ^ (32'(i) << 9)});
    do_go("R10 stalled output", 1, 1);
    // pokes during busy must not have added data
    do_go("R10 busy requests ignored", 0, 0);
  endtask

  task automatic t_collision();
    do_wr(36'haaa_5555_0);
    do_wr(36'h246_8ace_0);
    do_wr(36'h135_79bd_0);
    // write together with go: go wins
    void'(m_go());
    @(negedge clk_i); go_i = 1; wr_valid_i = 1; wr_data_i = 36'hfff_ffff_f;
    @(negedge clk_i); go_i = 0; wr_valid_i = 0;
    collect(0, 0);
    cmp_frame("R11 go beats write");
    do_go("R11 dropped write absent", 0, 0);
    // clear together with go: clear wins
    do_wr(36'h777_0001_0);
    @(negedge clk_i); go_i = 1; clr_tx_i = 1;
    @(negedge clk_i); go_i = 0; clr_tx_i = 0;
    m_cnt = 0; m_done = 1; m_err = 0;
    repeat (2) @(negedge clk_i);
    check(busy_o === 0 && tx_done_o === 1, "R11 clear beats go", {busy_o, tx_done_o}, 2'b01);
    do_wr(36'h314_1592_6);
    do_go("R11 only post-clear data", 0, 0);
  endtask

  task automatic t_overflow();
    do_clr();
    for (int i = 0; i < 129; i++) do_wr({8'(i), 8'(~i), 8'(i + 3), 8'(i ^ 8'h5a), 4'h0});
    check(len_err_o === 0, "R4 no error at 516", len_err_o, 0);
    do_wr(36'h0de_adbe_e);
    check(len_err_o === 1, "R4 write past limit", len_err_o, 1);
    do_go("R6 long frame", 0, 0);
    do_clr();
    @(negedge clk_i);
    check(len_err_o === 0 && tx_done_o === 1, "R11 clear resets status",
          {len_err_o, tx_done_o}, 2'b01);
    for (int i = 0; i < 128; i++) do_wr({8'(i + 1), 8'(i * 3), 8'(i), 8'hc3, 4'h0});
    do_go("R6 512 refused", 0, 0);
    do_clr();
    for (int i = 0; i < 127; i++) do_wr({8'(i * 7), 8'(i + 9), 8'(~i), 8'(i * 5), 4'h0});
    half_i = 1;
    do_wr(36'hbee_f000_0);
    half_i = 0;
    do_go("R6 510 accepted", 1, 0);
  endtask

  initial begin
    #(5ns * 150000);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 516; i++) mb[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_swap();
    t_half();
    t_backpressure();
    t_collision();
    t_overflow();
    repeat (3) @(negedge clk_i);
    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule